// File: doc/BRIEF.md
# Stream-bridged 16550-style UART register block

This block presents the familiar 16550 UART register set to a CPU over a 32-bit Wishbone slave port, but carries the character traffic on two byte-wide valid/ready streams instead of a serial line. Bytes the CPU writes to the transmit holding register queue in a transmit FIFO and leave on the outbound stream. Bytes offered on the inbound stream queue in a receive FIFO until the CPU reads the receive buffer register.

Software written for the classic part keeps working. It sees the line status flags, the interrupt enable and identification registers, the FIFO control register, the line control register with its divisor-latch access bit, and two divisor bytes that are stored and read back. A level interrupt reports pending receive data and an empty transmit side.

Every bus cycle is acknowledged after a fixed single clock, even a read of an empty receive buffer. A CPU therefore never stalls on this block.

Top module: `uart_regbridge`

## Requirements
- R1: Every Wishbone cycle (cyc and stb high) is acknowledged by a one-clock ack pulse on the clock edge after the request. This includes a receive-buffer read while no byte is waiting, which returns 0x00.
- R2: After reset, IER reads 0x00, LCR reads 0x00, LSR reads 0x60 and IIR reads 0x01. irq and tx_valid_o are low and rx_ready_o is high.
- R3: A write at word 0 with select bit 3 set while LCR bit 7 is 0 queues wb_dat_i[7:0] for transmit. Queued bytes appear on tx_data_o in write order. While tx_ready_i is low, tx_valid_o stays high and tx_data_o stays stable.
- R4: A byte is taken from rx_data_i on each clock edge where rx_valid_i and rx_ready_o are both high. Reads at word 0 with select bit 3 set while LCR bit 7 is 0 return the taken bytes in arrival order. LSR bit 0 is 1 while at least one byte waits.
- R5: Each direction holds 16 bytes. A transmit write while 16 bytes are queued is discarded. rx_ready_o is low exactly while 16 received bytes are held.
- R6: LSR (word 4, select bit 2) has bits 5 and 6 set exactly while the transmit FIFO is empty. All its other bits except bit 0 read 0.
- R7: LCR bit 7 (divisor access) redirects select bit 3 to the low divisor byte and select bit 2 to the high divisor byte. Both bytes store and read back unchanged, and such accesses leave the FIFOs and IER untouched. IER keeps bits 3:0, and its bits 7:4 read 0.
- R8: Select bit 1 writes FCR and reads IIR. FCR bit 0 sets IIR bits 7:6 to 11. FCR bit 1 empties the receive FIFO. FCR bit 2 empties the transmit FIFO.
- R9: IIR bits 3:0 read 0100 when enabled receive data is pending. Otherwise they read 0010 when the enabled transmit-empty condition holds. Otherwise they read 0001.
- R10: irq equals (IER bit 0 AND receive data waiting) OR (IER bit 1 AND transmit FIFO empty), valid in the clock after the state changes. Writing IER to 0 drops irq after the next edge.
- R11: Read data bits 31:8 are always 0. A read at word 4 without select bit 2 returns 0.
- R12: When several select bits are set, a write updates every selected register. A read returns the register of the highest set select bit, and only that register's side effect takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | ADR_W | Byte address; bits above 1 select the word |
| wb_sel_i | input | 4 | Byte-lane selects choosing the register |
| wb_dat_i | input | 32 | Write data, byte in bits 7:0 |
| wb_dat_o | output | 32 | Read data, byte in bits 7:0 |
| wb_ack_o | output | 1 | Acknowledge |
| tx_data_o | output | 8 | Outbound byte |
| tx_valid_o | output | 1 | Outbound byte valid |
| tx_ready_i | input | 1 | Outbound sink ready |
| rx_data_i | input | 8 | Inbound byte |
| rx_valid_i | input | 1 | Inbound byte valid |
| rx_ready_o | output | 1 | Inbound space available |
| irq_o | output | 1 | Level interrupt |

## Verification
Ack and read data are registered on the edge that samples the request. The bench drives each request on a falling edge and reads ack and data on the next falling edge. Register writes, FIFO pushes and pops, and stream handshakes all take effect on that same rising edge. Status, IIR, irq, tx_valid_o and rx_ready_o are therefore checked at the falling edge right after the edge that caused the change, with no extra wait. Stream bytes are offered or consumed for exactly one rising edge per handshake, so each falling-edge sample sees exactly one FIFO step.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  typedef enum logic [2:0] {
    RS_NONE, RS_RBR, RS_DLL, RS_IER, RS_DLM, RS_IIR, RS_LCR, RS_LSR
  } rsel_e;

  localparam int LSR_DR   = 0;
  localparam int LSR_THRE = 5;
  localparam int LSR_TEMT = 6;
  localparam int LCR_DLAB = 7;

  localparam int IER_RX    = 0;
  localparam int IER_TX    = 1;
  localparam int IER_BITS  = 4;

  localparam int FCR_EN    = 0;
  localparam int FCR_RXCLR = 1;
  localparam int FCR_TXCLR = 2;

  localparam logic [3:0] IID_NONE    = 4'b0001;
  localparam logic [3:0] IID_RXDATA  = 4'b0100;
  localparam logic [3:0] IID_TXEMPTY = 4'b0010;
endpackage

// File: rtl/uart_rb_fifo.sv
module uart_rb_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full & ~clr;
  assign do_pop  = pop & ~empty & ~clr;
  assign rdata   = mem_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= wdata;
  end
endmodule

// File: rtl/uart_rb_busif.sv
module uart_rb_busif
  import uart_rb_pkg::*;
#(
  parameter int ADR_W = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             cyc,
  input  logic             stb,
  input  logic             we,
  input  logic [ADR_W-1:0] adr,
  input  logic [3:0]       sel,
  input  logic [31:0]      dat_i,
  input  logic             dlab,
  input  logic [7:0]       rd_byte,
  output logic             ack,
  output logic [31:0]      dat_o,
  output logic [7:0]       wbyte,
  output logic             thr_wr,
  output logic             dll_wr,
  output logic             ier_wr,
  output logic             dlm_wr,
  output logic             fcr_wr,
  output logic             lcr_wr,
  output logic             rbr_rd,
  output rsel_e            rsel
);
  localparam int IW = ADR_W - 2;

  logic [IW-1:0] widx;
  logic          req, word0, word1, wr_req, rd_req;
  logic          ack_q, ack_d;
  logic [31:0]   dat_q, dat_d;
  logic          dat_en;
  logic          unused_bits;

  assign widx   = adr[ADR_W-1:2];
  assign word0  = (widx == IW'(0));
  assign word1  = (widx == IW'(1));
  assign req    = cyc & stb & ~ack_q;
  assign wr_req = req & we;
  assign rd_req = req & ~we;
  assign wbyte  = dat_i[7:0];
  assign unused_bits = ^{dat_i[31:8], adr[1:0]};

  assign thr_wr = wr_req & word0 & sel[3] & ~dlab;
  assign dll_wr = wr_req & word0 & sel[3] &  dlab;
  assign ier_wr = wr_req & word0 & sel[2] & ~dlab;
  assign dlm_wr = wr_req & word0 & sel[2] &  dlab;
  assign fcr_wr = wr_req & word0 & sel[1];
  assign lcr_wr = wr_req & word0 & sel[0];

  always_comb begin
    rsel = RS_NONE;
    if (rd_req && word0) begin
      if (sel[3])      rsel = dlab ? RS_DLL : RS_RBR;
      else if (sel[2]) rsel = dlab ? RS_DLM : RS_IER;
      else if (sel[1]) rsel = RS_IIR;
      else if (sel[0]) rsel = RS_LCR;
    end else if (rd_req && word1) begin
      if (sel[2]) rsel = RS_LSR;
    end
  end

  assign rbr_rd = (rsel == RS_RBR);

  assign ack_d  = req;
  assign dat_en = rd_req;
  assign dat_d  = {24'h0, rd_byte};

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      dat_q <= '0;
    end else begin
      ack_q <= ack_d;
      if (dat_en) dat_q <= dat_d;
    end
  end

  assign ack   = ack_q;
  assign dat_o = dat_q;
endmodule

// File: rtl/uart_rb_regfile.sv
module uart_rb_regfile
  import uart_rb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic [7:0] wbyte,
  input  logic       dll_wr,
  input  logic       ier_wr,
  input  logic       dlm_wr,
  input  logic       fcr_wr,
  input  logic       lcr_wr,
  input  rsel_e      rsel,
  input  logic [7:0] rx_head,
  input  logic       rx_empty,
  input  logic       tx_empty,
  output logic [7:0] rd_byte,
  output logic       dlab,
  output logic       irq
);
  logic [IER_BITS-1:0] ier_q, ier_d;
  logic [7:0]          lcr_q, lcr_d;
  logic [7:0]          dll_q, dll_d;
  logic [7:0]          dlm_q, dlm_d;
  logic                fen_q, fen_d;
  logic                rx_pend, tx_pend;
  logic [3:0]          iid;
  logic [7:0]          lsr, iir;

  always_comb begin
    ier_d = ier_q;
    lcr_d = lcr_q;
    dll_d = dll_q;
    dlm_d = dlm_q;
    fen_d = fen_q;
    if (ier_wr) ier_d = wbyte[IER_BITS-1:0];
    if (lcr_wr) lcr_d = wbyte;
    if (dll_wr) dll_d = wbyte;
    if (dlm_wr) dlm_d = wbyte;
    if (fcr_wr) fen_d = wbyte[FCR_EN];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q <= '0;
      lcr_q <= '0;
      dll_q <= '0;
      dlm_q <= '0;
      fen_q <= 1'b0;
    end else begin
      ier_q <= ier_d;
      lcr_q <= lcr_d;
      dll_q <= dll_d;
      dlm_q <= dlm_d;
      fen_q <= fen_d;
    end
  end

  assign dlab    = lcr_q[LCR_DLAB];
  assign rx_pend = ier_q[IER_RX] & ~rx_empty;
  assign tx_pend = ier_q[IER_TX] & tx_empty;
  assign irq     = rx_pend | tx_pend;

  always_comb begin
    if (rx_pend)      iid = IID_RXDATA;
    else if (tx_pend) iid = IID_TXEMPTY;
    else              iid = IID_NONE;
  end

  assign iir = {fen_q, fen_q, 2'b00, iid};

  always_comb begin
    lsr           = '0;
    lsr[LSR_DR]   = ~rx_empty;
    lsr[LSR_THRE] = tx_empty;
    lsr[LSR_TEMT] = tx_empty;
  end

  always_comb begin
    case (rsel)
      RS_RBR:  rd_byte = rx_empty ? 8'h00 : rx_head;
      RS_DLL:  rd_byte = dll_q;
      RS_IER:  rd_byte = {{(8-IER_BITS){1'b0}}, ier_q};
      RS_DLM:  rd_byte = dlm_q;
      RS_IIR:  rd_byte = iir;
      RS_LCR:  rd_byte = lcr_q;
      RS_LSR:  rd_byte = lsr;
      default: rd_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/uart_regbridge.sv
module uart_regbridge
  import uart_rb_pkg::*;
#(
  parameter int ADR_W      = 4,
  parameter int FIFO_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_cyc_i,
  input  logic             wb_stb_i,
  input  logic             wb_we_i,
  input  logic [ADR_W-1:0] wb_adr_i,
  input  logic [3:0]       wb_sel_i,
  input  logic [31:0]      wb_dat_i,
  output logic [31:0]      wb_dat_o,
  output logic             wb_ack_o,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_valid_i,
  output logic             rx_ready_o,
  output logic             irq_o
);
  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  logic [7:0] wbyte, rd_byte, rx_head;
  logic       thr_wr, dll_wr, ier_wr, dlm_wr, fcr_wr, lcr_wr, rbr_rd;
  logic       dlab, rx_empty, rx_full, tx_empty, tx_full;
  logic       rx_clr, tx_clr;
  rsel_e      rsel;

  uart_rb_busif #(.ADR_W(ADR_W)) u_bus (
    .clk(clk), .rst_ni(rst_ni),
    .cyc(wb_cyc_i), .stb(wb_stb_i), .we(wb_we_i), .adr(wb_adr_i),
    .sel(wb_sel_i), .dat_i(wb_dat_i), .dlab(dlab), .rd_byte(rd_byte),
    .ack(wb_ack_o), .dat_o(wb_dat_o), .wbyte(wbyte),
    .thr_wr(thr_wr), .dll_wr(dll_wr), .ier_wr(ier_wr), .dlm_wr(dlm_wr),
    .fcr_wr(fcr_wr), .lcr_wr(lcr_wr), .rbr_rd(rbr_rd), .rsel(rsel)
  );

  uart_rb_regfile u_regs (
    .clk(clk), .rst_ni(rst_ni), .wbyte(wbyte),
    .dll_wr(dll_wr), .ier_wr(ier_wr), .dlm_wr(dlm_wr),
    .fcr_wr(fcr_wr), .lcr_wr(lcr_wr), .rsel(rsel),
    .rx_head(rx_head), .rx_empty(rx_empty), .tx_empty(tx_empty),
    .rd_byte(rd_byte), .dlab(dlab), .irq(irq_o)
  );

  assign rx_clr = fcr_wr & wbyte[FCR_RXCLR];
  assign tx_clr = fcr_wr & wbyte[FCR_TXCLR];

  uart_rb_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_ni(rst_ni), .clr(tx_clr),
    .push(thr_wr), .wdata(wbyte),
    .pop(tx_valid_o & tx_ready_i), .rdata(tx_data_o),
    .empty(tx_empty), .full(tx_full)
  );

  uart_rb_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_ni(rst_ni), .clr(rx_clr),
    .push(rx_valid_i & rx_ready_o), .wdata(rx_data_i),
    .pop(rbr_rd), .rdata(rx_head),
    .empty(rx_empty), .full(rx_full)
  );

  assign tx_valid_o = ~tx_empty;
  assign rx_ready_o = ~rx_full;

  logic unused_txfull;
  assign unused_txfull = tx_full;
endmodule

// File: rtl/uart_regbridge_chk.sv
module uart_regbridge_chk #(
  parameter int ADR_W = 4
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             wb_cyc_i,
  input logic             wb_stb_i,
  input logic             wb_we_i,
  input logic [ADR_W-1:0] wb_adr_i,
  input logic [3:0]       wb_sel_i,
  input logic [7:0]       wdat,
  input logic             wb_ack_o,
  input logic [7:0]       tx_data_o,
  input logic             tx_valid_o,
  input logic             tx_ready_i,
  input logic             rx_ready_o,
  input logic             rx_empty,
  input logic             dlab,
  input logic             irq_o
);
  logic req, w0, tx_flush, ier_zero;
  logic unused_chk;

  assign unused_chk = ^wb_adr_i[1:0];
  assign req      = wb_cyc_i & wb_stb_i & ~wb_ack_o;
  assign w0       = (wb_adr_i[ADR_W-1:2] == '0);
  assign tx_flush = req & wb_we_i & w0 & wb_sel_i[1] & wdat[2];
  assign ier_zero = req & wb_we_i & w0 & (wb_sel_i == 4'b0100) & ~dlab & (wdat == 8'h00);

  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_ni)
    req |=> wb_ack_o);  // R1
  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_ni)
    wb_ack_o |-> $past(wb_cyc_i && wb_stb_i));  // R1
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !tx_flush) |=> (tx_valid_o && $stable(tx_data_o)));  // R3
  AST_RX_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_ni)
    !rx_ready_o |-> !rx_empty);  // R5
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_ni)
    ier_zero |=> !irq_o);  // R10
endmodule

bind uart_regbridge uart_regbridge_chk #(.ADR_W(ADR_W)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i),
  .wb_we_i(wb_we_i), .wb_adr_i(wb_adr_i), .wb_sel_i(wb_sel_i),
  .wdat(wb_dat_i[7:0]), .wb_ack_o(wb_ack_o), .tx_data_o(tx_data_o),
  .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .rx_ready_o(rx_ready_o),
  .rx_empty(rx_empty), .dlab(dlab), .irq_o(irq_o)
);

// File: tb/uart_regbridge_test.sv
`timescale 1ns/1ps
module uart_regbridge_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc, stb, we;
  logic [3:0]  adr, sel;
  logic [31:0] dat_i, dat_o;
  logic        ack;
  logic [7:0]  tx_data, rx_data;
  logic        tx_valid, tx_ready, rx_valid, rx_ready, irq;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  uart_regbridge uut (
    .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_sel_i(sel), .wb_dat_i(dat_i), .wb_dat_o(dat_o),
    .wb_ack_o(ack), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .rx_ready_o(rx_ready), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [3:0] a, input logic [3:0] s,
                      input logic [7:0] d, output logic [31:0] q);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; sel = s; dat_i = {24'hABCDEF, d};
    @(posedge clk);
    @(negedge clk);
    chk("R1 ack after one clock", {31'h0, ack}, 32'h1);
    q = dat_o;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] s, input logic [7:0] d);
    logic [31:0] q;
    xfer(1'b1, a, s, d, q);
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [3:0] s,
                        input logic [31:0] exp);
    logic [31:0] q;
    xfer(1'b0, a, s, 8'h00, q);
    chk(tag, q, exp);
  endtask

  task automatic rx_send(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R2 irq at reset", {31'h0, irq}, 32'h0);
    chk("R2 tx_valid at reset", {31'h0, tx_valid}, 32'h0);
    chk("R2 rx_ready at reset", {31'h0, rx_ready}, 32'h1);
    rd_chk("R2 IER reset", 4'h0, 4'h4, 32'h00);
    rd_chk("R2 LCR reset", 4'h0, 4'h1, 32'h00);
    rd_chk("R2 LSR reset", 4'h4, 4'h4, 32'h60);
    rd_chk("R2 IIR reset", 4'h0, 4'h2, 32'h01);
    rd_chk("R1 empty RBR read", 4'h0, 4'h8, 32'h00);
    rd_chk("R11 word 4 other lane", 4'h4, 4'h8, 32'h00);
  endtask

  task automatic t_tx;
    tx_ready = 1'b0;
    wr(4'h0, 4'h8, 8'h11);
    wr(4'h0, 4'h8, 8'h22);
    wr(4'h0, 4'h8, 8'h33);
    rd_chk("R6 LSR with tx queued", 4'h4, 4'h4, 32'h00);
    chk("R3 tx_valid", {31'h0, tx_valid}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R3 tx head held", {24'h0, tx_data}, 32'h11);
    tx_ready = 1'b1;
    chk("R3 tx byte 0", {24'h0, tx_data}, 32'h11);
    @(negedge clk);
    chk("R3 tx byte 1", {24'h0, tx_data}, 32'h22);
    @(negedge clk);
    chk("R3 tx byte 2", {24'h0, tx_data}, 32'h33);
    @(negedge clk);
    chk("R3 tx drained", {31'h0, tx_valid}, 32'h0);
    rd_chk("R6 LSR after drain", 4'h4, 4'h4, 32'h60);
  endtask

  task automatic t_rx;
    rx_send(8'hA1);
    rx_send(8'hB2);
    rx_send(8'hC3);
    rd_chk("R4 LSR data ready", 4'h4, 4'h4, 32'h61);
    rd_chk("R4 rx byte 0", 4'h0, 4'h8, 32'hA1);
    rd_chk("R4 rx byte 1", 4'h0, 4'h8, 32'hB2);
    rd_chk("R4 rx byte 2", 4'h0, 4'h8, 32'hC3);
    rd_chk("R4 LSR empty", 4'h4, 4'h4, 32'h60);
    rd_chk("R1 RBR read when empty", 4'h0, 4'h8, 32'h00);
  endtask

  task automatic t_full;
    int good;
    tx_ready = 1'b0;
    for (int k = 0; k < 17; k++) wr(4'h0, 4'h8, 8'(8'h40 + k));
    tx_ready = 1'b1;
    good = 0;
    for (int k = 0; k < 16; k++) begin
      if (tx_valid === 1'b1 && tx_data === 8'(8'h40 + k)) good++;
      @(negedge clk);
    end
    chk("R5 sixteen tx bytes in order", good, 16);
    chk("R5 seventeenth tx write dropped", {31'h0, tx_valid}, 32'h0);
    for (int k = 0; k < 16; k++) rx_send(8'(8'h80 + k));
    chk("R5 rx_ready low when full", {31'h0, rx_ready}, 32'h0);
    rx_send(8'hEE);
    good = 0;
    for (int k = 0; k < 16; k++) begin
      logic [31:0] q;
      xfer(1'b0, 4'h0, 4'h8, 8'h00, q);
      if (q === 32'(8'h80 + k)) good++;
    end
    chk("R5 sixteen rx bytes, extra refused", good, 16);
    rd_chk("R5 rx empty after reads", 4'h4, 4'h4, 32'h60);
  endtask

  task automatic t_dlab;
    wr(4'h0, 4'h1, 8'h80);
    rd_chk("R7 LCR divisor bit", 4'h0, 4'h1, 32'h80);
    wr(4'h0, 4'h8, 8'h5A);
    wr(4'h0, 4'h4, 8'hA5);
    rd_chk("R7 low divisor", 4'h0, 4'h8, 32'h5A);
    rd_chk("R7 high divisor", 4'h0, 4'h4, 32'hA5);
    chk("R7 no tx push", {31'h0, tx_valid}, 32'h0);
    rd_chk("R7 LSR untouched", 4'h4, 4'h4, 32'h60);
    wr(4'h0, 4'h1, 8'h00);
    rd_chk("R7 IER untouched", 4'h0, 4'h4, 32'h00);
  endtask

  task automatic t_fcr;
    wr(4'h0, 4'h2, 8'h01);
    rd_chk("R8 IIR fifo bits", 4'h0, 4'h2, 32'hC1);
    tx_ready = 1'b0;
    wr(4'h0, 4'h8, 8'h01);
    wr(4'h0, 4'h8, 8'h02);
    rx_send(8'h77);
    rx_send(8'h78);
    rd_chk("R8 LSR before flush", 4'h4, 4'h4, 32'h01);
    wr(4'h0, 4'h2, 8'h07);
    rd_chk("R8 LSR after flush", 4'h4, 4'h4, 32'h60);
    chk("R8 tx flushed", {31'h0, tx_valid}, 32'h0);
    rd_chk("R8 IIR keeps fifo bits", 4'h0, 4'h2, 32'hC1);
  endtask

  task automatic t_irq;
    tx_ready = 1'b0;
    wr(4'h0, 4'h4, 8'h01);
    chk("R10 irq low, rx empty", {31'h0, irq}, 32'h0);
    rx_send(8'h5C);
    chk("R10 irq on rx byte", {31'h0, irq}, 32'h1);
    rd_chk("R9 IIR rx pending", 4'h0, 4'h2, 32'hC4);
    rd_chk("R4 rx byte for irq", 4'h0, 4'h8, 32'h5C);
    chk("R10 irq cleared by read", {31'h0, irq}, 32'h0);
    wr(4'h0, 4'h4, 8'h02);
    chk("R10 irq tx empty", {31'h0, irq}, 32'h1);
    rd_chk("R9 IIR tx empty", 4'h0, 4'h2, 32'hC2);
    wr(4'h0, 4'h8, 8'h99);
    chk("R10 irq drops on THR write", {31'h0, irq}, 32'h0);
    tx_ready = 1'b1;
    @(negedge clk);
    chk("R10 irq back after byte left", {31'h0, irq}, 32'h1);
    wr(4'h0, 4'h4, 8'h03);
    rx_send(8'h6D);
    rd_chk("R9 rx has precedence", 4'h0, 4'h2, 32'hC4);
    wr(4'h0, 4'h4, 8'h00);
    chk("R10 irq off with IER zero", {31'h0, irq}, 32'h0);
    rd_chk("R9 IIR none", 4'h0, 4'h2, 32'hC1);
    rd_chk("R4 drain rx", 4'h0, 4'h8, 32'h6D);
  endtask

  task automatic t_multi;
    wr(4'h0, 4'h5, 8'h73);
    rd_chk("R12 LCR via multi write", 4'h0, 4'h1, 32'h73);
    rd_chk("R12 IER via multi write, high bits", 4'h0, 4'h4, 32'h03);
    rx_send(8'h3E);
    rd_chk("R12 read priority sel2 over sel1", 4'h0, 4'h6, 32'h03);
    rd_chk("R12 read priority sel3 top", 4'h0, 4'hF, 32'h3E);
    rd_chk("R12 only RBR popped", 4'h4, 4'h4, 32'h60);
    wr(4'h0, 4'h4, 8'hF0);
    rd_chk("R7 IER upper bits read zero", 4'h0, 4'h4, 32'h00);
    wr(4'h0, 4'h1, 8'h00);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R1 watchdog: actual hang expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cyc = 1'b0; stb = 1'b0; we = 1'b0; adr = '0; sel = '0; dat_i = '0;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_tx();
    t_rx();
    t_full();
    t_dlab();
    t_fcr();
    t_irq();
    t_multi();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule